// File: doc/BRIEF.md
# Keyed Shutdown and Pad-Latch Controller

This block lets software put the device into its deepest power-down state and brings the I/O pads back cleanly after wakeup. Shutdown is requested by a write of an exact 16-bit key to a write-only register. The controller answers with a one-cycle request pulse that goes to the power sequencer. Any other value has no effect, so a stray write cannot power the device down.

A single pad-sleep bit drives the pad-latch enable. While the bit is 0, the pad cells hold their outputs and configuration, and pads used as inputs stay transparent. Software writes the bit to 1 once it has set the pads up again after wakeup. That same write also clears two sticky flags. One flag records that the device woke from shutdown, and the other records that an I/O event caused that wakeup. A two-bit wake-source field tells software whether the last wakeup came from standby or from reset or shutdown.

The register bus is a simple single-cycle strobe interface with combinational read data.

Top module: `shdn_ctrl`

## Requirements
- R1: A write of 0xA5A5 to bits [15:0] of the key register (offset 0x0) raises `shdn_req` for exactly one cycle. The pulse appears in the cycle after the clock edge that accepts the write. A write with any other value in bits [15:0] raises no pulse.
- R2: Bits [31:16] of a key-register write are ignored. A write with 0xA5A5 in the low half triggers R1 whatever the upper half holds.
- R3: The key register has no stored state and always reads 0, including after a valid key write.
- R4: The pad-sleep bit is bit 0 at offset 0x4. It can be read and written, and it resets to 0. `pad_latch_en` is 1 while this bit is 0 and 0 while it is 1, and it changes one cycle after the write.
- R5: The wake-source field is bits [1:0] at offset 0x8. It holds 1 (woke from reset or shutdown) or 2 (woke from standby), and it never holds any other value.
- R6: A `wake_shdn` pulse sets the shutdown-wake flag (bit 0 at offset 0xC). If `wake_io` is high in the same cycle, the pulse also sets the I/O-wake flag (bit 1 at offset 0xC). Both flags stay set until R7 clears them.
- R7: A write of 1 to the pad-sleep bit clears both wake flags on the same edge. If a `wake_shdn` pulse arrives in that same cycle, the set wins.
- R8: A `wake_stby` pulse sets the wake source to 2. A `wake_shdn` pulse sets it to 1, and it takes priority when both pulses arrive together.
- R9: Reset (synchronous, active low) sets the wake source to 1, clears both flags, and clears the pad-sleep bit, which makes `pad_latch_en` 1.
- R10: Bits outside the defined fields read as 0. Addresses with no register also read as 0. Writes to undefined bits change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write happens at the rising clock edge |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wake_stby | input | 1 | One-cycle pulse: wakeup from standby |
| wake_shdn | input | 1 | One-cycle pulse: wakeup from shutdown |
| wake_io | input | 1 | Qualifies `wake_shdn`: the wakeup came from an I/O |
| shdn_req | output | 1 | One-cycle shutdown request |
| pad_latch_en | output | 1 | 1 = pads hold their outputs and configuration |

## Verification
The hardest case to reach is the overlap of a flag-clearing write to the pad-sleep bit with a new shutdown wake event in the same cycle. The order of set and clear decides whether that wakeup is lost. The bench drives both strobes in one cycle and reads the flags back at the next sampling point. It also sends key writes whose upper half is nonzero, and key values one bit away from the magic key, to show that only the low half is compared and that the match is exact.

// File: rtl/shdn_pkg.sv
// Package: shared register offsets, key value and wake-source codes.
// Assumes byte addresses with one 32-bit word per register.
package shdn_pkg;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned KEY_W  = 16;
    parameter logic [KEY_W-1:0] SHDN_KEY = 16'hA5A5;

    parameter int unsigned OFF_KEY  = 0;
    parameter int unsigned OFF_SLP  = 4;
    parameter int unsigned OFF_SRC  = 8;
    parameter int unsigned OFF_FLAG = 12;

    typedef enum logic [1:0] {
        SRC_RST_SHDN = 2'd1,
        SRC_STBY     = 2'd2
    } wake_src_e;
endpackage

// File: rtl/shdn_bus_dec.sv
// Module: address decoder and read mux for the controller's registers.
// Assumes: writes take effect at the clock edge; reads are combinational.
module shdn_bus_dec
    import shdn_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              slp_bit,
    input  logic [1:0]        src_val,
    input  logic [1:0]        flag_val,
    output logic              wr_key,
    output logic              wr_slp,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
    localparam logic [ADDR_W-1:0] A_SLP  = ADDR_W'(OFF_SLP);
    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFF_SRC);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFF_FLAG);

    // Write strobes, one per writable register.
    always_comb begin
        wr_key = bus_wr && (bus_addr == A_KEY);
        wr_slp = bus_wr && (bus_addr == A_SLP);
    end

    // Read mux; the key register and unknown addresses read as zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_SLP:   bus_rdata[0]   = slp_bit;
            A_SRC:   bus_rdata[1:0] = src_val;
            A_FLAG:  bus_rdata[1:0] = flag_val;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/shdn_key_gate.sv
// Module: compares the key write with the magic value and issues a one-cycle request.
// Assumes: only the low KEY_W bits of the write word are given to it.
module shdn_key_gate #(
    parameter int unsigned    KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_key,
    input  logic [KEY_W-1:0] key_in,
    output logic             req
);
    logic hit;

    // Exact match of the full key field.
    always_comb hit = wr_key && (key_in == KEY);

    // Register the match so the request is a clean single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= hit;
    end
endmodule

// File: rtl/shdn_wake_track.sv
// Module: pad-sleep bit, sticky wake flags and wake-source field.
// Assumes: wake inputs are single-cycle pulses synchronous to clk.
module shdn_wake_track
    import shdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_slp,
    input  logic       slp_wbit,
    input  logic       wake_stby,
    input  logic       wake_shdn,
    input  logic       wake_io,
    output logic       slp_bit,
    output logic [1:0] src_val,
    output logic [1:0] flag_val
);
    wake_src_e  src_q;
    logic [1:0] flag_q;
    logic       clr_flags;

    always_comb clr_flags = wr_slp && slp_wbit;

    // Pad-sleep bit, written directly by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      slp_bit <= 1'b0;
        else if (wr_slp) slp_bit <= slp_wbit;
    end

    // Sticky wake flags; a new wake event wins over the clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 2'b00;
        end else begin
            if (clr_flags) flag_q <= 2'b00;
            if (wake_shdn) begin
                flag_q[0] <= 1'b1;
                if (wake_io) flag_q[1] <= 1'b1;
            end
        end
    end

    // Wake source; a shutdown wakeup outranks a standby wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n)         src_q <= SRC_RST_SHDN;
        else if (wake_shdn) src_q <= SRC_RST_SHDN;
        else if (wake_stby) src_q <= SRC_STBY;
    end

    always_comb begin
        src_val  = src_q;
        flag_val = flag_q;
    end
endmodule

// File: rtl/shdn_ctrl.sv
// Module: top of the keyed shutdown and pad-latch controller.
// Assumes: one register access per cycle; wake pulses come from the wake logic.
module shdn_ctrl
    import shdn_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_stby,
    input  logic              wake_shdn,
    input  logic              wake_io,
    output logic              shdn_req,
    output logic              pad_latch_en
);
    logic       wr_key, wr_slp, slp_bit;
    logic [1:0] src_val, flag_val;

    shdn_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .slp_bit(slp_bit),
        .src_val(src_val), .flag_val(flag_val),
        .wr_key(wr_key), .wr_slp(wr_slp), .bus_rdata(bus_rdata)
    );

    shdn_key_gate #(.KEY_W(KEY_W), .KEY(SHDN_KEY)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_key(wr_key),
        .key_in(bus_wdata[KEY_W-1:0]), .req(shdn_req)
    );

    shdn_wake_track u_wake (
        .clk(clk), .rst_n(rst_n), .wr_slp(wr_slp), .slp_wbit(bus_wdata[0]),
        .wake_stby(wake_stby), .wake_shdn(wake_shdn), .wake_io(wake_io),
        .slp_bit(slp_bit), .src_val(src_val), .flag_val(flag_val)
    );

    // Pads stay latched until software sets the pad-sleep bit.
    always_comb pad_latch_en = ~slp_bit;
endmodule

// File: rtl/shdn_ctrl_chk.sv
// Module: property checker for shdn_ctrl, attached with bind.
// Assumes: it sees the top's ports plus the internal flag and source state.
module shdn_ctrl_chk
    import shdn_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              wake_stby,
    input logic              wake_shdn,
    input logic              shdn_req,
    input logic              pad_latch_en,
    input logic [1:0]        src_val,
    input logic [1:0]        flag_val
);
    logic key_wr, good_key, slp_set;
    always_comb begin
        key_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_KEY));
        good_key = key_wr && (bus_wdata[KEY_W-1:0] == SHDN_KEY);
        slp_set  = bus_wr && (bus_addr == ADDR_W'(OFF_SLP)) && bus_wdata[0];
    end

    // R1: no request without a valid key write in the cycle before.
    a_r1_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
        !good_key |=> !shdn_req);

    // R2: any upper half with the right low half still triggers shutdown.
    a_r2_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (good_key && (bus_wdata[DATA_W-1:KEY_W] != '0)) |=> shdn_req);

    // R4: setting the pad-sleep bit releases the latch.
    a_r4_release_latch: assert property (@(posedge clk) disable iff (!rst_n)
        slp_set |=> !pad_latch_en);

    // R5: the wake source only ever holds one of its two codes.
    a_r5_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (src_val == 2'd1) || (src_val == 2'd2));

    // R7: a release write without a concurrent wake clears both flags.
    a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_set && !wake_shdn) |=> (flag_val == 2'b00));

    // R8: a lone standby wakeup reports standby as the source.
    a_r8_stby_src: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_stby && !wake_shdn) |=> (src_val == 2'd2));
endmodule

bind shdn_ctrl shdn_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wake_stby(wake_stby), .wake_shdn(wake_shdn),
    .shdn_req(shdn_req), .pad_latch_en(pad_latch_en),
    .src_val(src_val), .flag_val(flag_val)
);

// File: tb/shdn_ctrl_tb.sv
// Directed bench for shdn_ctrl: one task per scenario, each checking itself.
module shdn_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_stby = 1'b0, wake_shdn = 1'b0, wake_io = 1'b0;
    logic        shdn_req, pad_latch_en;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    shdn_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_stby(wake_stby),
        .wake_shdn(wake_shdn), .wake_io(wake_io), .shdn_req(shdn_req),
        .pad_latch_en(pad_latch_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Write lands at the next posedge; returns at the following negedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wake(input logic s, input logic sd, input logic io);
        @(negedge clk); wake_stby = s; wake_shdn = sd; wake_io = io;
        @(negedge clk); wake_stby = 0; wake_shdn = 0; wake_io = 0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        check("R9 req idle", 32'(shdn_req), 0);
        check("R9 pad latched", 32'(pad_latch_en), 1);
        rd(4'h4, d); check("R9 sleep bit", d, 0);
        rd(4'h8, d); check("R5 src reset", d, 1);
        rd(4'hC, d); check("R9 flags", d, 0);
        rd(4'h0, d); check("R3 key reads 0", d, 0);
    endtask

    task automatic t_valid_key();
        logic [31:0] d;
        wr(4'h0, 32'h0000_A5A5);
        check("R1 pulse", 32'(shdn_req), 1);
        @(negedge clk);
        check("R1 single cycle", 32'(shdn_req), 0);
        rd(4'h0, d); check("R3 key reads 0 after write", d, 0);
        wr(4'h0, 32'hFFFF_A5A5);
        check("R2 upper ignored", 32'(shdn_req), 1);
    endtask

    task automatic t_bad_keys();
        logic [31:0] bad_vals [4] = '{32'h0000_A5A4, 32'h0000_5A5A, 32'h0000_0000, 32'hA5A5_0000};
        foreach (bad_vals[i]) begin
            wr(4'h0, bad_vals[i]);
            check("R1 wrong key no pulse", 32'(shdn_req), 0);
        end
        wr(4'h4, 32'h0000_A5A5); // right key, wrong register: sets pad-sleep bit only
        check("R1 key at other address", 32'(shdn_req), 0);
        wr(4'h4, 32'h0);
    endtask

    task automatic t_wake_flags();
        logic [31:0] d;
        wake(0, 1, 0);
        rd(4'hC, d); check("R6 shutdown flag only", d, 32'h1);
        rd(4'h8, d); check("R8 src after shutdown", d, 1);
        repeat (3) @(negedge clk);
        rd(4'hC, d); check("R6 flag held", d, 32'h1);
        wake(0, 1, 1);
        rd(4'hC, d); check("R6 io flag", d, 32'h3);
        wr(4'h4, 32'h1);
        check("R4 latch released", 32'(pad_latch_en), 0);
        rd(4'h4, d); check("R4 sleep bit reads 1", d, 1);
        rd(4'hC, d); check("R7 flags cleared", d, 0);
    endtask

    task automatic t_clear_race();
        logic [31:0] d;
        wr(4'h4, 32'h0);
        check("R4 relatched", 32'(pad_latch_en), 1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h1; wake_shdn = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; wake_shdn = 1'b0;
        rd(4'hC, d); check("R7 set wins over clear", d, 32'h1);
        wr(4'h4, 32'h1);
        rd(4'hC, d); check("R7 clear after race", d, 0);
    endtask

    task automatic t_src();
        logic [31:0] d;
        wake(1, 0, 0);
        rd(4'h8, d); check("R8 standby src", d, 2);
        rd(4'hC, d); check("R8 standby sets no flag", d, 0);
        wake(1, 1, 0);
        rd(4'h8, d); check("R8 shutdown priority", d, 1);
        wake(1, 0, 0);
        do_reset();
        rd(4'h8, d); check("R9 reset restores src", d, 1);
        check("R9 pad latched after reset", 32'(pad_latch_en), 1);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R10 sleep reserved read 0", d, 1);
        wr(4'h4, 32'hFFFF_FFFE);
        rd(4'h4, d); check("R10 reserved write no effect", d, 0);
        check("R10 latch follows bit 0 only", 32'(pad_latch_en), 1);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, d); check("R10 src not writable", d, 1);
        rd(4'h6, d); check("R10 unmapped reads 0", d, 0);
    endtask

    initial begin
        t_reset_state();
        t_valid_key();
        t_bad_keys();
        t_wake_flags();
        t_clear_race();
        t_src();
        t_reserved();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule